// File: doc/BRIEF.md
# ADC Serial Result Formatter

This block is the output side of a converter with a serial host link. It holds one 12-bit conversion result and shifts it onto a serial data line. A host drives an I/O clock and an active-low chip select. Three format controls shape each transfer:

- the transfer length (8, 12 or 16 bits);
- the bit order (most or least significant bit first);
- the number coding (straight binary, or offset binary with the top bit used as the sign).

The format and the result are both captured when the end-of-conversion level rises. Later changes to those inputs therefore only shape the next transfer.

The I/O clock and the chip select come from outside the system clock domain. Both are synchronized, and edges are detected on the system clock. The first bit is on the line as soon as a new result is captured, whether chip select is low then or only falls later. Each later falling edge of the I/O clock advances the line by one bit. While a conversion runs, the line is forced to 0. The line is reported as driven only while chip select is low.

Top module: `adc_serial_fmt`

## Requirements
- R1: While and right after reset, `data_o` is 0 and `data_oe_o` is 0.
- R2: With `fmt_bipolar_i`=0 the result is sent as straight binary (mid-scale 12'h800 is a one followed by zeros). With `fmt_bipolar_i`=1 the result's top bit is inverted (mid-scale sends all zeros, full-scale 12'hFFF sends 0 then ones).
- R3: `fmt_len_i` 2'b01 sends the 8 upper result bits. 2'b00 or 2'b10 sends all 12 bits. 2'b11 sends 16 bits: the 12 result bits and then four zero pads below the LSB.
- R4: With `fmt_lsb_first_i`=1 the selected bits go out in reverse order. In 16-bit mode the four zero pads therefore go out first.
- R5: Format and result are sampled on the rising edge of `conv_done_i`. Changing them later does not alter the transfer in progress, and the new values apply to the next captured result.
- R6: The first bit of a new result is on `data_o` within 2 system clocks after `conv_done_i` rises. If chip select was high meanwhile, that same first bit is shown once chip select falls.
- R7: Each falling edge of `sclk_i` with chip select low moves `data_o` to the next bit within 4 system clocks. Without such an edge, `data_o` holds.
- R8: Once all selected bits have been sent, further falling edges of `sclk_i` drive `data_o` to 0.
- R9: While `conv_done_i` is low, `data_o` is 0 from the next system clock on.
- R10: `data_oe_o` follows the inverted chip select after at most 3 system clocks.
- R11: Falling edges of `sclk_i` while chip select is high do not advance the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| result_i | input | 12 | Conversion result, sampled when `conv_done_i` rises |
| conv_done_i | input | 1 | End-of-conversion level, low while converting |
| fmt_len_i | input | 2 | Transfer length: 01 = 8, 11 = 16, otherwise 12 |
| fmt_lsb_first_i | input | 1 | 1 = least significant bit first |
| fmt_bipolar_i | input | 1 | 1 = top bit inverted (signed coding) |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Host I/O clock, asynchronous |
| data_o | output | 1 | Serial data |
| data_oe_o | output | 1 | High while `data_o` is driven |

## Verification
A wrong frame word shows up as a bad first bit within two clocks of the capture. A bad coding, length mask or reversal only shows up as the bits are walked out, one I/O clock fall at a time. A shift that is lost or doubled corrupts every later bit of the transfer and also leaves a stray bit in place of the trailing zeros. A failure to clear during a conversion is seen on the next system clock, before the result is captured.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    LEN_12  = 2'b00,
    LEN_8   = 2'b01,
    LEN_12B = 2'b10,
    LEN_16  = 2'b11
  } len_sel_e;

  typedef struct packed {
    len_sel_e len;
    logic     lsb_first;
    logic     bipolar;
  } fmt_t;
endpackage

// File: rtl/adc_fmt_sync.sv
module adc_fmt_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~level_o;

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R7
endmodule

// File: rtl/adc_fmt_frame.sv
module adc_fmt_frame
  import adc_fmt_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int FRAME_W = 16,
  parameter int SHORT_W = 8,
  localparam int PAD_W  = FRAME_W - RES_W,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic [RES_W-1:0]   result_i,
  input  fmt_t               fmt_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [RES_W-1:0]   coded;
  logic [CNT_W-1:0]   nbits;
  logic [FRAME_W-1:0] kept;
  logic [FRAME_W-1:0] rev;

  // signed coding: flip the top bit only
  assign coded = result_i ^ {fmt_i.bipolar, {(RES_W-1){1'b0}}};

  always_comb begin
    unique case (fmt_i.len)
      LEN_8:   nbits = CNT_W'(SHORT_W);
      LEN_16:  nbits = CNT_W'(FRAME_W);
      default: nbits = CNT_W'(RES_W);
    endcase
  end

  // MSB-justified, keep only the top nbits
  assign kept = {coded, {PAD_W{1'b0}}} & ~({FRAME_W{1'b1}} >> nbits);

  for (genvar i = 0; i < FRAME_W; i++) begin : g_rev
    assign rev[i] = kept[FRAME_W-1-i];
  end

  assign frame_o = fmt_i.lsb_first ? (rev << (FRAME_W - int'(nbits))) : kept;
endmodule

// File: rtl/adc_fmt_shift.sv
module adc_fmt_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               conv_done_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               data_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sh_q <= '0;
    else if (!conv_done_i) sh_q <= '0;
    else if (load_i)       sh_q <= frame_i;
    else if (shift_i)      sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign data_o = sh_q[FRAME_W-1];

  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && conv_done_i) |=> data_o == $past(frame_i[FRAME_W-1])); // R6
  AST_BUSY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> !data_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !load_i && !shift_i) |=> $stable(data_o)); // R7
  AST_DRAIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !load_i && shift_i) |=> $countones(sh_q) <= $past($countones(sh_q))); // R8
endmodule

// File: rtl/adc_serial_fmt.sv
module adc_serial_fmt
  import adc_fmt_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int FRAME_W     = 16,
  parameter int SHORT_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] result_i,
  input  logic             conv_done_i,
  input  logic [1:0]       fmt_len_i,
  input  logic             fmt_lsb_first_i,
  input  logic             fmt_bipolar_i,
  input  logic             cs_ni,
  input  logic             sclk_i,
  output logic             data_o,
  output logic             data_oe_o
);
  localparam int PAD_W = FRAME_W - RES_W;

  fmt_t               fmt;
  logic [FRAME_W-1:0] frame;
  logic               done_q;
  logic               load;
  logic               sclk_lvl, sclk_fall, fall_q;
  logic               cs_lvl, cs_fall;
  logic               shift;

  assign fmt = '{len: len_sel_e'(fmt_len_i), lsb_first: fmt_lsb_first_i,
                 bipolar: fmt_bipolar_i};

  adc_fmt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk_i, .rst_ni, .async_i(sclk_i), .level_o(sclk_lvl), .fall_o(sclk_fall)
  );

  adc_fmt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .async_i(cs_ni), .level_o(cs_lvl), .fall_o(cs_fall)
  );

  adc_fmt_frame #(.RES_W(RES_W), .FRAME_W(FRAME_W), .SHORT_W(SHORT_W)) u_frame (
    .result_i, .fmt_i(fmt), .frame_o(frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      done_q <= conv_done_i;
      fall_q <= sclk_fall;
    end
  end

  // capture on end-of-conversion rise; shift one clock after a detected fall
  assign load  = conv_done_i & ~done_q;
  assign shift = fall_q & ~cs_lvl;

  adc_fmt_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i, .rst_ni, .conv_done_i, .load_i(load), .frame_i(frame),
    .shift_i(shift), .data_o
  );

  assign data_oe_o = ~cs_lvl;

  AST_SIGN_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !fmt_lsb_first_i) |-> frame[FRAME_W-1] == (result_i[RES_W-1] ^ fmt_bipolar_i)); // R2
  AST_PAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !fmt_lsb_first_i && fmt_len_i == 2'b11) |-> frame[PAD_W-1:0] == '0); // R3
  AST_PAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && fmt_lsb_first_i && fmt_len_i == 2'b11) |-> frame[FRAME_W-1 -: PAD_W] == '0); // R4
  AST_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_oe_o && conv_done_i && !load) |=> $stable(data_o)); // R11
  AST_OE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |-> data_oe_o); // R10
endmodule

// File: tb/adc_serial_fmt_tb.sv
module adc_serial_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] result = '0;
  logic        conv_done = 1'b1;
  logic [1:0]  fmt_len = 2'b00;
  logic        fmt_lsb = 1'b0;
  logic        fmt_bip = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        data, data_oe;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  adc_serial_fmt u_dut (
    .clk_i(clk), .rst_ni, .result_i(result), .conv_done_i(conv_done),
    .fmt_len_i(fmt_len), .fmt_lsb_first_i(fmt_lsb), .fmt_bipolar_i(fmt_bip),
    .cs_ni(cs_n), .sclk_i(sclk), .data_o(data), .data_oe_o(data_oe)
  );

  localparam int NV = 10;
  localparam logic [11:0] V_RES [NV] = '{12'hA5C, 12'hA5C, 12'hA5C, 12'hA5C, 12'hA5C,
                                         12'hA5C, 12'h800, 12'h800, 12'hFFF, 12'hA5C};
  localparam logic [1:0]  V_LEN [NV] = '{2'b00, 2'b01, 2'b11, 2'b00, 2'b11,
                                         2'b01, 2'b00, 2'b00, 2'b11, 2'b10};
  localparam logic        V_LSB [NV] = '{0, 0, 0, 1, 1, 1, 0, 0, 0, 0};
  localparam logic        V_BIP [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 1, 0};
  // expected stream, first bit at [15], unsent positions zero
  localparam logic [15:0] V_EXP [NV] = '{16'hA5C0, 16'hA500, 16'hA5C0, 16'h3A50, 16'h03A5,
                                         16'hA400, 16'h0000, 16'h8000, 16'h7FF0, 16'hA5C0};

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int len_bits(input logic [1:0] l);
    return (l == 2'b01) ? 8 : (l == 2'b11) ? 16 : 12;
  endfunction

  task automatic sclk_pulse();
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    sclk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic capture(input logic [11:0] r, input logic [1:0] l, input logic lsb,
                         input logic bip);
    @(negedge clk);
    result = r; fmt_len = l; fmt_lsb = lsb; fmt_bip = bip;
    conv_done = 1'b0;
    repeat (3) @(negedge clk);
    check(data == 1'b0, "R9 busy", {15'd0, data}, 16'd0);
    conv_done = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic walk(input int n, input logic [15:0] exp, input string req);
    logic [15:0] got = '0;
    got[15] = data;
    for (int i = 1; i < n; i++) begin
      sclk_pulse();
      got[15-i] = data;
    end
    check(got == exp, req, got, exp);
    sclk_pulse();
    check(data == 1'b0, "R8 drain", {15'd0, data}, 16'd0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic held;
    repeat (3) @(negedge clk);
    check(data == 1'b0 && data_oe == 1'b0, "R1 in reset", {14'd0, data_oe, data}, 16'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(data == 1'b0 && data_oe == 1'b0, "R1 after reset", {14'd0, data_oe, data}, 16'd0);

    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check(data_oe == 1'b1, "R10 select", {15'd0, data_oe}, 16'd1);

    // table: coding, length, order (R2, R3, R4, R6, R7)
    for (int v = 0; v < NV; v++) begin
      capture(V_RES[v], V_LEN[v], V_LSB[v], V_BIP[v]);
      check(data == V_EXP[v][15], "R6 first bit", {15'd0, data}, {15'd0, V_EXP[v][15]});
      walk(len_bits(V_LEN[v]), V_EXP[v], $sformatf("R2/R3/R4/R7 vec %0d", v));
    end

    // R5: format change after capture leaves the running transfer intact
    capture(12'hA5C, 2'b00, 1'b0, 1'b0);
    fmt_len = 2'b01; fmt_lsb = 1'b1; fmt_bip = 1'b1; result = 12'h000;
    walk(12, 16'hA5C0, "R5 running frame");
    capture(12'h000, 2'b01, 1'b1, 1'b1);
    walk(8, 16'h0100, "R5 next frame");

    // R11/R6/R10: chip select high across capture and I/O clock activity
    @(negedge clk);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    check(data_oe == 1'b0, "R10 deselect", {15'd0, data_oe}, 16'd0);
    capture(12'hA5C, 2'b00, 1'b0, 1'b0);
    repeat (3) sclk_pulse();
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    check(data_oe == 1'b1 && data == 1'b1, "R11 no shift while deselected",
          {14'd0, data_oe, data}, 16'd3);
    held = data;
    repeat (20) @(negedge clk);
    check(data == held, "R7 hold without edge", {15'd0, data}, {15'd0, held});
    sclk_pulse();
    check(data == 1'b0, "R7 second bit", {15'd0, data}, 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule